// File: doc/BRIEF.md
# Load-Use Interlock Controller

This block decides, each cycle, whether an in-order five-stage pipeline must hold for one cycle because the instruction in decode needs a value that a load in execute has not yet fetched from memory. All other read-after-write cases are left to the forwarding network, so the controller reacts only to a load whose destination is read by the very next instruction.

The controller compares the execute-stage destination register against the two decode-stage source registers. A source counts only when its use flag is set. The destination counts only when the execute-stage instruction both reads memory and writes a register, and the destination is not register 0. On a match it freezes the program counter and the fetch/decode stage register. It also selects an all-zero control word into the decode/execute register, which sends a bubble down the pipe. The outputs are pure combinational functions of the stage-register fields. The clock and reset are used only to time the built-in property checks.

Top module: `hazard_ctrl`

## Requirements
- R1: The hold condition is asserted when exec_rd_mem=1, exec_wr_reg=1 and exec_dst is nonzero, and exec_dst equals dec_rs_a with dec_use_a=1, or equals dec_rs_b with dec_use_b=1.
- R2: While the hold condition is asserted, pc_wr_en=0 and fd_wr_en=0.
- R3: While the hold condition is asserted, bubble_sel=1. A 1 on bubble_sel selects all-zero control into the decode/execute register.
- R4: When the hold condition is not asserted, pc_wr_en=1, fd_wr_en=1 and bubble_sel=0.
- R5: A source field whose use flag is 0 never causes a hold, whatever register number it carries.
- R6: An exec_dst of 0 never causes a hold.
- R7: No hold occurs unless both exec_rd_mem=1 and exec_wr_reg=1. A store or an ALU producer never holds.
- R8: The outputs follow input changes within the same cycle, with no clock edge needed.
- R9: A load followed at once by a consumer costs exactly one hold cycle once the bubble reaches execute. A consumer two instructions after the load causes no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to sample the property checks |
| rst_n | input | 1 | Asynchronous active-low reset, disables the property checks |
| dec_rs_a | input | REG_W | First source register number of the decode-stage instruction |
| dec_use_a | input | 1 | First source is read by the decode-stage instruction |
| dec_rs_b | input | REG_W | Second source register number of the decode-stage instruction |
| dec_use_b | input | 1 | Second source is read by the decode-stage instruction |
| exec_dst | input | REG_W | Destination register number of the execute-stage instruction |
| exec_rd_mem | input | 1 | Execute-stage instruction reads data memory |
| exec_wr_reg | input | 1 | Execute-stage instruction writes a register |
| pc_wr_en | output | 1 | Program counter may update |
| fd_wr_en | output | 1 | Fetch/decode stage register may update |
| bubble_sel | output | 1 | Select all-zero control into decode/execute |

## Verification
Two functions can fall in the same cycle: a hit on the first source and a hit on the second source. Both can also coincide with a filter that must cancel them, which is an unused field, a register-0 destination or a non-load producer. The bench sweeps every destination against every first-source number, with the second source set both equal and unequal to the destination, under all use-flag and producer-flag combinations. Each case is judged against an expected hold value that the bench computes arithmetically. A short pipeline sequence then checks that the hold lasts exactly one cycle.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  // register number width (32 architectural registers)
  parameter int unsigned REG_W = 5;
  // number of decode-stage source operands compared
  parameter int unsigned SRC_N = 2;
endpackage

// File: rtl/reg_cmp.sv
module reg_cmp #(
  parameter int unsigned W = hazard_pkg::REG_W
) (
  input  logic [W-1:0] src_num,
  input  logic         src_used,
  input  logic [W-1:0] dst_num,
  input  logic         dst_live,
  output logic         hit
);
  // equality compare gated by both qualifiers
  always_comb begin
    hit = src_used && dst_live && (src_num == dst_num);
  end
endmodule

// File: rtl/ex_producer.sv
module ex_producer #(
  parameter int unsigned W = hazard_pkg::REG_W
) (
  input  logic [W-1:0] dst_num,
  input  logic         rd_mem,
  input  logic         wr_reg,
  output logic         live
);
  // only a register-writing load with a real destination can hazard
  always_comb begin
    live = rd_mem && wr_reg && (|dst_num);
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int unsigned REG_W = hazard_pkg::REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] dec_rs_a,
  input  logic             dec_use_a,
  input  logic [REG_W-1:0] dec_rs_b,
  input  logic             dec_use_b,
  input  logic [REG_W-1:0] exec_dst,
  input  logic             exec_rd_mem,
  input  logic             exec_wr_reg,
  output logic             pc_wr_en,
  output logic             fd_wr_en,
  output logic             bubble_sel
);
  localparam int unsigned SRC_N = hazard_pkg::SRC_N;

  logic [REG_W-1:0] src_num  [SRC_N];
  logic [SRC_N-1:0] src_used;
  logic [SRC_N-1:0] src_hit;
  logic             dst_live;
  logic             hold;

  always_comb begin
    src_num[0]  = dec_rs_a;
    src_num[1]  = dec_rs_b;
    src_used[0] = dec_use_a;
    src_used[1] = dec_use_b;
  end

  ex_producer #(.W(REG_W)) u_prod (
    .dst_num (exec_dst),
    .rd_mem  (exec_rd_mem),
    .wr_reg  (exec_wr_reg),
    .live    (dst_live)
  );

  for (genvar g = 0; g < SRC_N; g++) begin : g_cmp
    reg_cmp #(.W(REG_W)) u_cmp (
      .src_num  (src_num[g]),
      .src_used (src_used[g]),
      .dst_num  (exec_dst),
      .dst_live (dst_live),
      .hit      (src_hit[g])
    );
  end

  always_comb begin
    hold       = |src_hit;
    pc_wr_en   = !hold;
    fd_wr_en   = !hold;
    bubble_sel = hold;
  end

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |-> (!pc_wr_en && !fd_wr_en)); // R2
  AST_RUN_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    !bubble_sel |-> (pc_wr_en && fd_wr_en)); // R4
  AST_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |-> (exec_rd_mem && exec_wr_reg)); // R7
  AST_ZERO_DST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_dst == '0) |-> !bubble_sel); // R6
  AST_UNUSED_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_use_a && !dec_use_b) |-> !bubble_sel); // R5
  AST_MATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_rd_mem && exec_wr_reg && exec_dst != '0 && dec_use_a && dec_rs_a == exec_dst)
      |-> bubble_sel); // R1
endmodule

// File: tb/hazard_ctrl_bench.sv
`timescale 1ns/1ps
module hazard_ctrl_bench;
  logic       clk;
  logic       rst_n;
  logic [4:0] rs_a, rs_b, dst;
  logic       use_a, use_b, rd_mem, wr_reg;
  logic       pc_we, fd_we, bub;
  int         total;
  int         bad;
  int         cyc;

  hazard_ctrl u_hazard_ctrl (
    .clk(clk), .rst_n(rst_n),
    .dec_rs_a(rs_a), .dec_use_a(use_a), .dec_rs_b(rs_b), .dec_use_b(use_b),
    .exec_dst(dst), .exec_rd_mem(rd_mem), .exec_wr_reg(wr_reg),
    .pc_wr_en(pc_we), .fd_wr_en(fd_we), .bubble_sel(bub)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input logic exp_hold, input string tag);
    logic [2:0] act, exp;
    act = {pc_we, fd_we, bub};
    exp = {~exp_hold, ~exp_hold, exp_hold};
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%b expected=%b (rs_a=%0d ua=%b rs_b=%0d ub=%b dst=%0d rd=%b wr=%b)",
               tag, act, exp, rs_a, use_a, rs_b, use_b, dst, rd_mem, wr_reg);
    end
  endtask

  task automatic drive(input logic [4:0] a, input logic ua, input logic [4:0] b,
                       input logic ub, input logic [4:0] d, input logic rd,
                       input logic wr);
    rs_a = a; use_a = ua; rs_b = b; use_b = ub; dst = d; rd_mem = rd; wr_reg = wr;
  endtask

  task automatic step(input logic [4:0] a, input logic ua, input logic [4:0] b,
                      input logic ub, input logic [4:0] d, input logic rd,
                      input logic wr, input logic exp_hold, input string tag);
    @(negedge clk);
    drive(a, ua, b, ub, d, rd, wr);
    #1;
    check(exp_hold, tag);
  endtask

  initial begin
    total = 0; bad = 0; cyc = 0;
    rst_n = 1'b0;
    drive(5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #1 check(1'b0, "R4 reset state");
    @(negedge clk) rst_n = 1'b1;

    // directed cases
    step(5'd5, 1, 5'd7, 1, 5'd5, 1, 1, 1'b1, "R1 first source hit");
    step(5'd5, 1, 5'd7, 1, 5'd7, 1, 1, 1'b1, "R1 second source hit");
    step(5'd9, 1, 5'd9, 1, 5'd9, 1, 1, 1'b1, "R1 both sources hit");
    step(5'd3, 1, 5'd4, 1, 5'd3, 1, 1, 1'b1, "R2 freeze on hold");
    step(5'd3, 1, 5'd4, 1, 5'd3, 1, 1, 1'b1, "R3 bubble on hold");
    step(5'd3, 1, 5'd4, 1, 5'd8, 1, 1, 1'b0, "R4 no match runs");
    step(5'd6, 1, 5'd6, 0, 5'd6, 1, 1, 1'b1, "R5 used a still hits");
    step(5'd1, 0, 5'd6, 0, 5'd6, 1, 1, 1'b0, "R5 unused b ignored");
    step(5'd6, 0, 5'd2, 1, 5'd6, 1, 1, 1'b0, "R5 unused a ignored");
    step(5'd0, 1, 5'd0, 1, 5'd0, 1, 1, 1'b0, "R6 zero destination");
    step(5'd4, 1, 5'd0, 0, 5'd4, 0, 1, 1'b0, "R7 alu producer");
    step(5'd4, 1, 5'd0, 0, 5'd4, 1, 0, 1'b0, "R7 no reg write");

    // R8: change mid-cycle, no edge in between
    @(negedge clk);
    drive(5'd10, 1, 5'd11, 1, 5'd12, 1, 1);
    #0.5 check(1'b0, "R8 before change");
    dst = 5'd11;
    #0.5 check(1'b1, "R8 same-cycle rise");
    rd_mem = 1'b0;
    #0.5 check(1'b0, "R8 same-cycle fall");

    // R9: load x5 then consumer: hold, then bubble in execute releases
    step(5'd5, 1, 5'd0, 0, 5'd5, 1, 1, 1'b1, "R9 load-use hold");
    step(5'd5, 1, 5'd0, 0, 5'd0, 0, 0, 1'b0, "R9 bubble releases");
    // load x5, independent, then consumer of x5 (load now two ahead)
    step(5'd2, 1, 5'd3, 1, 5'd5, 1, 1, 1'b0, "R9 independent after load");
    step(5'd5, 1, 5'd5, 1, 5'd8, 0, 1, 1'b0, "R9 distance two no hold");

    // near-exhaustive sweep
    for (int d = 0; d < 32; d++) begin
      for (int a = 0; a < 32; a++) begin
        for (int bsel = 0; bsel < 2; bsel++) begin
          for (int f = 0; f < 16; f++) begin
            logic [4:0] b;
            logic ua, ub, rd, wr, live, exp;
            string tag;
            b  = (bsel == 0) ? 5'(d) : 5'(d ^ 1);
            ua = f[0]; ub = f[1]; rd = f[2]; wr = f[3];
            live = rd && wr && (d != 0);
            exp  = live && ((ua && a == d) || (ub && b == 5'(d)));
            if (!(rd && wr))    tag = "R7 sweep";
            else if (d == 0)    tag = "R6 sweep";
            else if (!exp && ((a == d) || (b == 5'(d)))) tag = "R5 sweep";
            else if (exp)       tag = "R3 sweep";
            else                tag = "R1 sweep";
            @(negedge clk);
            drive(5'(a), ua, b, ub, 5'(d), rd, wr);
            #1;
            check(exp, tag);
          end
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule